// File: doc/BRIEF.md
# Multi-Lane SPI Transaction Master

This block is a half-duplex SPI master that runs one bus transaction for each accepted command. A transaction always opens with an 8-bit command byte and a 24-bit target address, both sent on a single lane. A data phase of a programmable number of bytes follows. The command byte also decides two things about the data phase: whether the master writes or the device answers, and whether the data moves on one, two or four lines.

The host loads a command through the command port: opcode, address, byte count and a one-cycle start strobe. For writes, it supplies bytes on a byte input that the block consumes one at a time. For reads, it collects bytes from a byte output that carries a one-cycle valid strobe. The serial clock comes from the system clock through a programmable half-period ratio, which is captured at the start of each transaction. The pins are the serial clock, an active-low chip select, four bidirectional data lines split into output values, output enables and input values.

Top module: `spi_mio_master`

## Requirements
- R1: While reset is asserted and afterwards until a command is accepted, chip select is high, the serial clock is low, all four output enables are 0 and busy is low.
- R2: Every transaction first sends the opcode and then the 24-bit address, 32 bits in total, most significant bit first on IO0 only. During these 32 clocks the output-enable vector is 4'b0001.
- R3: The opcode selects the data phase. 0x02 is a 1-lane write, 0x0B a 1-lane read, 0xB2 a 2-lane write, 0xBB a 2-lane read, 0xE2 a 4-lane write and 0xEB a 4-lane read. A transaction therefore lasts 32 + 8*N/lanes serial clocks for N data bytes.
- R4: Data bits go most significant first. With 1 lane, writes leave on IO0 and reads are sampled on IO1. With 2 lanes, IO1 carries bit 7 and IO0 bit 6 of the first clock, so a byte takes 4 clocks. With 4 lanes, IO3..IO0 carry bits 7..4 in the first clock, so a byte takes 2 clocks.
- R5: In a write data phase the block takes exactly N bytes from wr_data_i, pulsing wr_pop_o for one cycle on the clock edge that takes each byte. The output enables are 4'b0001, 4'b0011 or 4'b1111 for 1, 2 or 4 lanes.
- R6: In a read data phase all output enables drop to 0 on the falling serial-clock edge that ends the address and stay 0 until chip select rises. Each received byte appears on rd_data_o with a one-cycle rd_valid_o pulse.
- R7: The bus uses SPI mode 0. The serial clock idles low, outputs change only together with a falling edge, and inputs are sampled on the rising edge. Each half period lasts div_i+1 system clocks, with div_i captured when the command is accepted.
- R8: Chip select goes low in the cycle after the command is accepted and stays low until the falling edge after the last bit. It rises in that same cycle, in which done_o pulses once. busy_o is high for the whole transaction.
- R9: An opcode outside the six of R3 produces a one-cycle err_o pulse and no chip-select, clock or output-enable activity; busy_o stays low.
- R10: A start strobe that arrives while a transaction is running is ignored. The running transaction completes unchanged and no further transaction follows.
- R11: A byte count of zero gives a transaction of opcode and address only (32 clocks), with no write byte taken and no read byte delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Serial-clock half period minus one, in system clocks |
| cmd_valid_i | input | 1 | Start strobe for a command |
| cmd_op_i | input | 8 | Opcode |
| cmd_addr_i | input | 24 | Target address |
| cmd_len_i | input | LEN_W | Number of data bytes |
| wr_data_i | input | 8 | Next write byte |
| wr_pop_o | output | 1 | Write byte taken this cycle |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o holds a new byte |
| busy_o | output | 1 | Transaction running |
| done_o | output | 1 | Transaction finished this cycle |
| err_o | output | 1 | Command rejected |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| io_o | output | 4 | Output values for IO3..IO0 |
| io_oe_o | output | 4 | Output enables for IO3..IO0 |
| io_i | input | 4 | Input values of IO3..IO0 |

## Verification
The hardest point to reach is the turnaround of a read. The master must release IO1 and the other lanes on exactly the falling edge that ends the address. It must then sample only the lanes that the opcode names. The bench device model starts driving its first data beat at that very falling edge. It drives the complements of the wanted bits on the lanes that should be ignored, so a late release, an early sample or a wrong lane choice all corrupt the received bytes. A second start strobe is injected in the middle of a transaction to show that a command cannot be accepted while the bus is in use.

// File: rtl/spi_mio_pkg.sv
package spi_mio_pkg;

  typedef enum logic [1:0] {
    LN_ONE  = 2'd0,
    LN_TWO  = 2'd1,
    LN_FOUR = 2'd2
  } lanes_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_DATA = 2'd2
  } state_e;

  typedef struct packed {
    logic   valid;
    logic   rd;
    lanes_e ln;
  } opdec_t;

  localparam int HEAD_BITS = 32;
  localparam int BEAT_W    = $clog2(HEAD_BITS);

  // clocks per byte minus one for a lane width
  function automatic logic [BEAT_W-1:0] byte_last_beat(input lanes_e ln);
    case (ln)
      LN_TWO:  byte_last_beat = BEAT_W'(3);
      LN_FOUR: byte_last_beat = BEAT_W'(1);
      default: byte_last_beat = BEAT_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/spi_mio_opdec.sv
module spi_mio_opdec
  import spi_mio_pkg::*;
(
  input  logic [7:0] op_i,
  output opdec_t     dec_o
);

  always_comb begin
    dec_o = '{valid: 1'b1, rd: 1'b0, ln: LN_ONE};
    case (op_i)
      8'h02: dec_o = '{valid: 1'b1, rd: 1'b0, ln: LN_ONE};
      8'h0B: dec_o = '{valid: 1'b1, rd: 1'b1, ln: LN_ONE};
      8'hB2: dec_o = '{valid: 1'b1, rd: 1'b0, ln: LN_TWO};
      8'hBB: dec_o = '{valid: 1'b1, rd: 1'b1, ln: LN_TWO};
      8'hE2: dec_o = '{valid: 1'b1, rd: 1'b0, ln: LN_FOUR};
      8'hEB: dec_o = '{valid: 1'b1, rd: 1'b1, ln: LN_FOUR};
      default: dec_o = '{valid: 1'b0, rd: 1'b0, ln: LN_ONE};
    endcase
  end

endmodule

// File: rtl/spi_mio_tick.sv
module spi_mio_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_mio_lanes.sv
module spi_mio_lanes
  import spi_mio_pkg::*;
(
  input  lanes_e     ln_i,
  input  logic [7:0] top_i,
  input  logic [3:0] io_i,
  input  logic [6:0] rx_i,
  output logic [3:0] out_o,
  output logic [3:0] mask_o,
  output logic [7:0] rx_next_o
);

  always_comb begin
    case (ln_i)
      LN_TWO: begin
        out_o     = {2'b00, top_i[7:6]};
        mask_o    = 4'b0011;
        rx_next_o = {rx_i[5:0], io_i[1:0]};
      end
      LN_FOUR: begin
        out_o     = top_i[7:4];
        mask_o    = 4'b1111;
        rx_next_o = {rx_i[3:0], io_i[3:0]};
      end
      default: begin
        out_o     = {3'b000, top_i[7]};
        mask_o    = 4'b0001;
        rx_next_o = {rx_i[6:0], io_i[1]};
      end
    endcase
  end

endmodule

// File: rtl/spi_mio_master.sv
module spi_mio_master
  import spi_mio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_op_i,
  input  logic [23:0]      cmd_addr_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_pop_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);

  localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);
  localparam logic [BEAT_W-1:0] HEAD_LAST = BEAT_W'(HEAD_BITS - 1);

  state_e                   st_q, st_d;
  logic                     sclk_q, sclk_d;
  logic                     cs_n_q, cs_n_d;
  logic [HEAD_BITS-1:0]     sh_q, sh_d;
  logic [6:0]               rx_q, rx_d;
  logic [BEAT_W-1:0]        beat_q, beat_d;
  logic [LEN_W-1:0]         left_q, left_d;
  logic                     rd_q, rd_d;
  lanes_e                   ln_q, ln_d;
  logic [DIV_W-1:0]         div_q, div_d;
  logic [7:0]               rdata_q, rdata_d;
  logic                     rvalid_q, rvalid_d;
  logic                     done_q, done_d;
  logic                     err_q, err_d;
  logic                     pop;

  opdec_t                   dec;
  logic                     tick;
  lanes_e                   ln_eff;
  logic [3:0]               lane_out, lane_mask;
  logic [7:0]               rx_next;
  logic [HEAD_BITS-1:0]     sh_adv;

  spi_mio_opdec i_opdec (
    .op_i  (cmd_op_i),
    .dec_o (dec)
  );

  spi_mio_tick #(.DIV_W(DIV_W)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q != ST_IDLE),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign ln_eff = (st_q == ST_DATA) ? ln_q : LN_ONE;

  spi_mio_lanes i_lanes (
    .ln_i      (ln_eff),
    .top_i     (sh_q[HEAD_BITS-1 -: 8]),
    .io_i      (io_i),
    .rx_i      (rx_q),
    .out_o     (lane_out),
    .mask_o    (lane_mask),
    .rx_next_o (rx_next)
  );

  always_comb begin
    case (ln_eff)
      LN_TWO:  sh_adv = sh_q << 2;
      LN_FOUR: sh_adv = sh_q << 4;
      default: sh_adv = sh_q << 1;
    endcase
  end

  // next-state process
  always_comb begin
    st_d     = st_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    sh_d     = sh_q;
    rx_d     = rx_q;
    beat_d   = beat_q;
    left_d   = left_q;
    rd_d     = rd_q;
    ln_d     = ln_q;
    div_d    = div_q;
    rdata_d  = rdata_q;
    rvalid_d = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    pop      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          if (dec.valid) begin
            st_d   = ST_HEAD;
            cs_n_d = 1'b0;
            sclk_d = 1'b0;
            sh_d   = {cmd_op_i, cmd_addr_i};
            beat_d = HEAD_LAST;
            left_d = cmd_len_i;
            rd_d   = dec.rd;
            ln_d   = dec.ln;
            div_d  = div_i;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      default: begin
        if (tick) begin
          if (!sclk_q) begin
            // rising edge: sample
            sclk_d = 1'b1;
            if (st_q == ST_DATA && rd_q) begin
              rx_d = rx_next[6:0];
              if (beat_q == '0) begin
                rdata_d  = rx_next;
                rvalid_d = 1'b1;
              end
            end
          end else begin
            // falling edge: advance
            sclk_d = 1'b0;
            if (beat_q != '0) begin
              beat_d = beat_q - 1'b1;
              sh_d   = sh_adv;
            end else if ((st_q == ST_HEAD && left_q == '0) ||
                         (st_q == ST_DATA && left_q == LEN_ONE)) begin
              st_d   = ST_IDLE;
              cs_n_d = 1'b1;
              done_d = 1'b1;
            end else begin
              if (st_q == ST_DATA) left_d = left_q - 1'b1;
              st_d   = ST_DATA;
              beat_d = byte_last_beat(ln_q);
              if (!rd_q) begin
                sh_d = {wr_data_i, {(HEAD_BITS-8){1'b0}}};
                pop  = 1'b1;
              end
            end
          end
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      sh_q     <= '0;
      rx_q     <= '0;
      beat_q   <= '0;
      left_q   <= '0;
      rd_q     <= 1'b0;
      ln_q     <= LN_ONE;
      div_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      sclk_q   <= sclk_d;
      cs_n_q   <= cs_n_d;
      sh_q     <= sh_d;
      rx_q     <= rx_d;
      beat_q   <= beat_d;
      left_q   <= left_d;
      rd_q     <= rd_d;
      ln_q     <= ln_d;
      div_q    <= div_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_HEAD: io_oe_o = 4'b0001;
      ST_DATA: io_oe_o = rd_q ? 4'b0000 : lane_mask;
      default: io_oe_o = 4'b0000;
    endcase
  end

  assign io_o       = lane_out & io_oe_o;
  assign sclk_o     = sclk_q;
  assign cs_n_o     = cs_n_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rd_data_o  = rdata_q;
  assign rd_valid_o = rvalid_q;
  assign wr_pop_o   = pop;

endmodule

// File: rtl/spi_mio_master_chk.sv
module spi_mio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_o,
  input logic       sclk_o,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       rd_valid_o,
  input logic       wr_pop_o
);

  p_quiet_when_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (!sclk_o && io_oe_o == 4'b0000));

  p_outputs_move_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o) && !$fell(sclk_o)) |-> $stable(io_o & io_oe_o));

  p_release_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && io_oe_o == 4'b0000) |=> (cs_n_o || io_oe_o == 4'b0000));

  p_selected_means_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !sclk_o && $past(!cs_n_o)));

  p_reject_is_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cs_n_o && !busy_o));

  p_pop_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop_o |=> !wr_pop_o);

  p_rd_valid_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);

  p_direction_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pop_o && rd_valid_o));

endmodule

bind spi_mio_master spi_mio_master_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .io_o       (io_o),
  .io_oe_o    (io_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .rd_valid_o (rd_valid_o),
  .wr_pop_o   (wr_pop_o)
);

// File: tb/test_spi_mio_master.sv
`timescale 1ns/1ps
module test_spi_mio_master;

  localparam int DIV_W = 8;
  localparam int LEN_W = 8;

  logic             clk;
  logic             rst_n;
  logic [DIV_W-1:0] div_i;
  logic             cmd_valid_i;
  logic [7:0]       cmd_op_i;
  logic [23:0]      cmd_addr_i;
  logic [LEN_W-1:0] cmd_len_i;
  logic [7:0]       wr_data_i;
  logic             wr_pop_o;
  logic [7:0]       rd_data_o;
  logic             rd_valid_o;
  logic             busy_o, done_o, err_o;
  logic             sclk_o, cs_n_o;
  logic [3:0]       io_o, io_oe_o, io_i;

  spi_mio_master #(.DIV_W(DIV_W), .LEN_W(LEN_W)) i_spi_mio_master (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .cmd_valid_i(cmd_valid_i),
    .cmd_op_i(cmd_op_i), .cmd_addr_i(cmd_addr_i), .cmd_len_i(cmd_len_i),
    .wr_data_i(wr_data_i), .wr_pop_o(wr_pop_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    pat = s ^ (8'(k) * 8'h2D) ^ 8'(k);
  endfunction

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  len;
    logic [7:0]  seed;
    logic        rd;
    logic [2:0]  lanes;
    logic [7:0]  div;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 24'h123456, 8'd3, 8'hA5, 1'b0, 3'd1, 8'd1},
    '{8'h0B, 24'hABCDEF, 8'd3, 8'h3C, 1'b1, 3'd1, 8'd0},
    '{8'hB2, 24'h000001, 8'd4, 8'h81, 1'b0, 3'd2, 8'd2},
    '{8'hBB, 24'h800000, 8'd4, 8'h5A, 1'b1, 3'd2, 8'd1},
    '{8'hE2, 24'hF0F0F0, 8'd5, 8'h17, 1'b0, 3'd4, 8'd0},
    '{8'hEB, 24'h0F0F0F, 8'd5, 8'hE4, 1'b1, 3'd4, 8'd3},
    '{8'hE2, 24'h010203, 8'd0, 8'h99, 1'b0, 3'd4, 8'd1}
  };

  // bench device model state
  logic       cur_rd;
  int         cur_lanes;
  logic [7:0] cur_seed;
  int         m_rises, m_falls, m_wbits, m_wcnt, m_oe_head_bad, m_oe_data_bad;
  logic [31:0] m_head;
  logic [7:0] m_wbyte;
  logic [7:0] m_wcap [64];
  time        t_rise1, t_fall1;
  int         rd_cnt;
  logic [7:0] rd_cap [64];
  int         wr_idx;
  logic [3:0] data_mask;

  assign wr_data_i = pat(cur_seed, wr_idx);
  always_comb data_mask = (cur_lanes == 4) ? 4'b1111 : (cur_lanes == 2) ? 4'b0011 : 4'b0001;

  always @(posedge clk) if (wr_pop_o) wr_idx <= wr_idx + 1;

  always @(negedge clk) if (rd_valid_o && rd_cnt < 64) begin
    rd_cap[rd_cnt] = rd_data_o;
    rd_cnt++;
  end

  always @(posedge sclk_o) if (!cs_n_o) begin
    if (m_rises == 0) t_rise1 = $time;
    if (m_rises < 32) begin
      m_head = {m_head[30:0], io_o[0]};
      if (io_oe_o != 4'b0001) m_oe_head_bad++;
    end else if (!cur_rd) begin
      if (io_oe_o != data_mask) m_oe_data_bad++;
      if (cur_lanes == 4)      m_wbyte = {m_wbyte[3:0], io_o[3:0]};
      else if (cur_lanes == 2) m_wbyte = {m_wbyte[5:0], io_o[1:0]};
      else                     m_wbyte = {m_wbyte[6:0], io_o[0]};
      m_wbits += cur_lanes;
      if (m_wbits == 8) begin
        if (m_wcnt < 64) m_wcap[m_wcnt] = m_wbyte;
        m_wcnt++;
        m_wbits = 0;
      end
    end else begin
      if (io_oe_o != 4'b0000) m_oe_data_bad++;
    end
    m_rises++;
  end

  always @(negedge sclk_o) if (!cs_n_o) begin
    if (m_falls == 0) t_fall1 = $time;
    m_falls++;
    if (cur_rd && m_falls >= 32) begin
      int b, nb;
      logic [7:0] sb;
      b  = m_falls - 32;
      nb = 8 / cur_lanes;
      sb = pat(cur_seed, b / nb) << ((b % nb) * cur_lanes);
      // unused lanes carry the complement to expose wrong-lane sampling
      if (cur_lanes == 4)      io_i = sb[7:4];
      else if (cur_lanes == 2) io_i = {~sb[7], ~sb[6], sb[7:6]};
      else                     io_i = {2'b11, sb[7], ~sb[7]};
    end
  end

  task automatic run_vec(input vec_t v, input bit poke);
    int waited;
    bit seen_done;
    cur_rd = v.rd; cur_lanes = int'(v.lanes); cur_seed = v.seed;
    m_rises = 0; m_falls = 0; m_wbits = 0; m_wcnt = 0; m_head = '0;
    m_oe_head_bad = 0; m_oe_data_bad = 0; rd_cnt = 0; wr_idx = 0;
    @(negedge clk);
    cmd_op_i = v.op; cmd_addr_i = v.addr; cmd_len_i = v.len; div_i = v.div;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk("R8 busy after accept", 64'(busy_o), 64'd1);
    chk("R8 cs low after accept", 64'(cs_n_o), 64'd0);
    if (poke) begin
      repeat (6) @(negedge clk);
      cmd_op_i = 8'hEB; cmd_addr_i = 24'hFFFFFF; cmd_len_i = 8'd9; div_i = 8'd7;
      cmd_valid_i = 1'b1;
      @(negedge clk);
      cmd_valid_i = 1'b0;
    end
    seen_done = 1'b0;
    waited = 0;
    while (!seen_done && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (done_o) seen_done = 1'b1;
    end
    chk("R8 done pulse", 64'(seen_done), 64'd1);
    chk("R8 cs high at done", 64'(cs_n_o), 64'd1);
    chk("R2 opcode+address", 64'(m_head), 64'({v.op, v.addr}));
    chk("R2 header enables", 64'(m_oe_head_bad), 64'd0);
    chk("R3 clock count", 64'(m_rises), 64'(32 + int'(v.len) * 8 / int'(v.lanes)));
    chk("R7 high half period", 64'(t_fall1 - t_rise1), 64'((int'(v.div) + 1) * 20));
    if (v.rd) begin
      chk("R6 enables released", 64'(m_oe_data_bad), 64'd0);
      chk("R6 byte count", 64'(rd_cnt), 64'(v.len));
      for (int k = 0; k < int'(v.len); k++)
        chk("R6/R4 read byte", 64'(rd_cap[k]), 64'(pat(v.seed, k)));
    end else begin
      chk("R5 lane enables", 64'(m_oe_data_bad), 64'd0);
      chk("R5 bytes popped", 64'(wr_idx), 64'(v.len));
      chk("R5 bytes on bus", 64'(m_wcnt), 64'(v.len));
      for (int k = 0; k < int'(v.len); k++)
        chk("R5/R4 write byte", 64'(m_wcap[k]), 64'(pat(v.seed, k)));
    end
    if (v.len == 0) begin
      chk("R11 no write byte taken", 64'(wr_idx), 64'd0);
      chk("R11 no read byte", 64'(rd_cnt), 64'd0);
    end
    @(negedge clk);
    chk("R8 busy low after done", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit err_seen, cs_seen, busy_seen;
    rst_n = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_addr_i = '0;
    cmd_len_i = '0; div_i = '0; io_i = 4'b0000;
    cur_rd = 1'b0; cur_lanes = 1; cur_seed = '0; wr_idx = 0; rd_cnt = 0;
    m_rises = 0; m_falls = 0;
    repeat (3) @(negedge clk);
    chk("R1 cs in reset", 64'(cs_n_o), 64'd1);
    chk("R1 sclk in reset", 64'(sclk_o), 64'd0);
    chk("R1 enables in reset", 64'(io_oe_o), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", 64'(busy_o), 64'd0);
    chk("R1 cs after reset", 64'(cs_n_o), 64'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R9: unknown opcode
    @(negedge clk);
    cmd_op_i = 8'h55; cmd_addr_i = 24'h111111; cmd_len_i = 8'd2; div_i = 8'd0;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    err_seen = 1'b0; cs_seen = 1'b0; busy_seen = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (err_o) err_seen = 1'b1;
      if (!cs_n_o || sclk_o || io_oe_o != 0) cs_seen = 1'b1;
      if (busy_o) busy_seen = 1'b1;
      @(negedge clk);
    end
    chk("R9 error pulse", 64'(err_seen), 64'd1);
    chk("R9 no bus activity", 64'(cs_seen), 64'd0);
    chk("R9 never busy", 64'(busy_seen), 64'd0);

    // R10: start strobe during a running transaction
    run_vec(VECS[3], 1'b1);
    cs_seen = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (!cs_n_o) cs_seen = 1'b1;
      @(negedge clk);
    end
    chk("R10 no second transaction", 64'(cs_seen), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule